// File: doc/BRIEF.md
# SIMD Saturating Add/Subtract Unit

This unit performs packed integer addition or subtraction on two 128-bit vector operands. Each lane saturates independently instead of wrapping. A 2-bit code selects the lane width. Two further controls choose between add and subtract and between signed and unsigned arithmetic. When a lane's exact result does not fit in the lane, the lane takes the nearest representable bound instead. That bound is the all-ones or zero value for unsigned lanes, and the most-positive or most-negative value for signed lanes.

An active-length control selects whether all 128 bits take part or only the lower 64 bits. In the short form, the upper half of the result is written as zero. A registered sticky flag records that some active lane saturated since the flag was last cleared. The flag stays set until the dedicated clear input drops it. Results and the flag are captured on the rising edge of the clock when the valid input is high.

Top module: `simd_sat_addsub`

## Requirements
- R1: A synchronous active-high reset drives `result` to zero and `sat_flag` to 0 at the next clock edge.
- R2: `lane_sel` picks the lane width: 0 gives 8-bit lanes, 1 gives 16-bit, 2 gives 32-bit and 3 gives 64-bit. A lane whose exact result fits its range gives that exact result and does not set the flag.
- R3: With `op_sub`=0 and `is_signed`=0, a lane whose true sum exceeds the lane maximum yields all ones.
- R4: With `op_sub`=1 and `is_signed`=0, a lane whose first operand is smaller than its second yields zero.
- R5: With `op_sub`=0 and `is_signed`=1, an overflowing lane yields the most-positive value when the first operand is non-negative, and the most-negative value otherwise.
- R6: With `op_sub`=1 and `is_signed`=1, an overflowing lane is clamped by the same rule as R5, which is set by the sign of the first operand.
- R7: With `full_len`=0, bits 127:64 of the result are zero. Lanes in that upper half never set `sat_flag`.
- R8: A saturating active lane in a valid operation sets `sat_flag` at that clock edge. A valid operation without saturation leaves the flag set.
- R9: `clr_sat`=1 clears `sat_flag` at the next edge. If a saturating valid operation occurs in the same cycle, the flag ends at 1.
- R10: When `in_valid`=0, `result` holds its value and `sat_flag` cannot become set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture the operation this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract (first minus second) |
| is_signed | input | 1 | 1 = signed lanes, 0 = unsigned |
| lane_sel | input | 2 | Lane width code (R2) |
| full_len | input | 1 | 1 = 128 active bits, 0 = lower 64 bits only |
| clr_sat | input | 1 | Clear the sticky saturation flag |
| src_a | input | 128 | First operand |
| src_b | input | 128 | Second operand |
| result | output | 128 | Registered saturated result |
| sat_flag | output | 1 | Sticky cumulative saturation flag |

## Verification
Two things can land on the sticky flag in one cycle: an explicit clear and a valid operation. The bench drives `clr_sat` together with an operation that saturates, and expects the flag to read 1 afterwards. It then repeats the clear with an operation that does not saturate, and expects 0. A third case pairs the clear with a short-length operation whose only overflow sits in an inactive upper lane; the flag must then drop to 0.

// File: rtl/simd_sat_addsub.sv
module simd_sat_addsub #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             op_sub,
  input  logic             is_signed,
  input  logic [1:0]       lane_sel,
  input  logic             full_len,
  input  logic             clr_sat,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  output logic [VEC_W-1:0] result,
  output logic             sat_flag
);
  localparam int HALF_W = VEC_W / 2;

  logic [VEC_W-1:0] res_all [4];
  logic [3:0]       sat_all;

  for (genvar g = 0; g < 4; g++) begin : g_sz
    localparam int W = 8 << g;
    localparam int N = VEC_W / W;
    logic [N-1:0]     lane_hit;
    logic [VEC_W-1:0] packed_res;

    for (genvar i = 0; i < N; i++) begin : g_lane
      logic [W-1:0] a, b, bound;
      logic [W:0]   ext;
      logic         ovf;

      assign a   = src_a[i*W +: W];
      assign b   = src_b[i*W +: W];
      assign ext = op_sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});

      always_comb begin
        if (is_signed) begin
          ovf   = (op_sub ? (a[W-1] != b[W-1]) : (a[W-1] == b[W-1])) && (ext[W-1] != a[W-1]);
          bound = a[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end else begin
          ovf   = ext[W];
          bound = op_sub ? '0 : '1;
        end
      end

      assign packed_res[i*W +: W] = ovf ? bound : ext[W-1:0];
      assign lane_hit[i] = ovf && (full_len || (i < N / 2));
    end

    assign res_all[g] = packed_res;
    assign sat_all[g] = |lane_hit;
  end

  logic [VEC_W-1:0] res_sel;
  logic             sat_now;

  assign res_sel = res_all[lane_sel];
  assign sat_now = in_valid && sat_all[lane_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      sat_flag <= 1'b0;
    end else begin
      if (in_valid)
        result <= full_len ? res_sel : {{HALF_W{1'b0}}, res_sel[HALF_W-1:0]};
      if (sat_now)
        sat_flag <= 1'b1;
      else if (clr_sat)
        sat_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/simd_sat_addsub_chk.sv
module simd_sat_addsub_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             full_len,
  input logic             clr_sat,
  input logic [VEC_W-1:0] result,
  input logic             sat_flag
);
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  always @(negedge clk)
    if (rst_seen === 1'b1)
      a_r1_reset_state: assert (result == '0 && !sat_flag);

  a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
    in_valid && !full_len |=> result[VEC_W-1:VEC_W/2] == '0);

  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    sat_flag && !clr_sat |=> sat_flag);

  a_r9_clear_idle: assert property (@(posedge clk) disable iff (rst)
    clr_sat && !in_valid |=> !sat_flag);

  a_r10_hold_result: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  a_r10_set_needs_valid: assert property (@(posedge clk) disable iff (rst)
    $rose(sat_flag) |-> $past(in_valid));
endmodule

bind simd_sat_addsub simd_sat_addsub_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/simd_sat_addsub_tb.sv
module simd_sat_addsub_tb;
  logic         clk = 0;
  logic         rst, in_valid, op_sub, is_signed, full_len, clr_sat;
  logic [1:0]   lane_sel;
  logic [127:0] src_a, src_b, result;
  logic         sat_flag;
  int           n_chk = 0, n_bad = 0;
  logic         exp_sat = 0;
  logic [127:0] exp_res = '0;
  bit           done = 0;

  always #5 clk = ~clk;

  simd_sat_addsub u_dut (.*);

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic sub, sgn, input logic [1:0] sz,
                                input logic full, input logic [127:0] a, b,
                                output logic [127:0] r, output logic s);
    int w = 8 << sz;
    int n = 128 / w;
    logic [63:0] mask = (64'h1 << w) - 64'h1;
    r = '0; s = 0;
    for (int i = 0; i < n; i++) begin
      logic [63:0] ea, eb;
      logic signed [66:0] x, y, t, lo, hi;
      logic clamp;
      ea = 64'(a >> (i*w)) & mask;
      eb = 64'(b >> (i*w)) & mask;
      x = $signed({3'b0, ea});
      y = $signed({3'b0, eb});
      if (sgn) begin
        if (ea[w-1]) x = x - (67'sd1 <<< w);
        if (eb[w-1]) y = y - (67'sd1 <<< w);
        hi = (67'sd1 <<< (w-1)) - 1;
        lo = -(67'sd1 <<< (w-1));
      end else begin
        hi = (67'sd1 <<< w) - 1;
        lo = 0;
      end
      t = sub ? x - y : x + y;
      clamp = 0;
      if (t > hi) begin t = hi; clamp = 1; end
      if (t < lo) begin t = lo; clamp = 1; end
      if (full || i < n/2) begin
        s = s | clamp;
        r = r | (128'(t[63:0] & mask) << (i*w));
      end
    end
  endfunction

  task automatic do_op(string req, logic sub, sgn, logic [1:0] sz, logic full,
                       logic [127:0] a, b, logic clr);
    logic [127:0] er; logic es;
    @(negedge clk);
    in_valid = 1; op_sub = sub; is_signed = sgn; lane_sel = sz;
    full_len = full; src_a = a; src_b = b; clr_sat = clr;
    @(negedge clk);
    in_valid = 0; clr_sat = 0;
    model(sub, sgn, sz, full, a, b, er, es);
    exp_res = er;
    exp_sat = es ? 1'b1 : (clr ? 1'b0 : exp_sat);
    check(req, result, exp_res);
    check(req, 128'(sat_flag), 128'(exp_sat));
  endtask

  task automatic t_reset();
    check("R1", result, '0);
    check("R1", 128'(sat_flag), 0);
  endtask

  task automatic t_lanes();
    for (int sz = 0; sz < 4; sz++) begin
      do_op("R2", 0, 0, 2'(sz), 1, {16{8'h12}}, {16{8'h21}}, 0);
      do_op("R2", 1, 1, 2'(sz), 1, {16{8'h30}}, {16{8'h10}}, 0);
    end
    for (int k = 0; k < 40; k++)
      do_op("R2", 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
            {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom}, 1);
  endtask

  task automatic t_uadd();
    do_op("R3", 0, 0, 0, 1, {120'h0, 8'hFF}, {120'h0, 8'h01}, 1);
    check("R3", result[7:0], 8'hFF);
    do_op("R3", 0, 0, 3, 1, {64'h1, 64'hFFFF_FFFF_FFFF_FFF0}, {64'h2, 64'h20}, 1);
    check("R3", result, {64'h3, 64'hFFFF_FFFF_FFFF_FFFF});
  endtask

  task automatic t_usub();
    do_op("R4", 1, 0, 1, 1, {112'h0, 16'h0005}, {112'h0, 16'h0009}, 1);
    check("R4", result[15:0], 16'h0);
    do_op("R4", 1, 0, 2, 1, {4{32'h10}}, {4{32'h11}}, 1);
  endtask

  task automatic t_sadd();
    do_op("R5", 0, 1, 0, 1, {112'h0, 8'h80, 8'h7F}, {112'h0, 8'hFF, 8'h01}, 1);
    check("R5", result[15:0], 16'h807F);
    do_op("R5", 0, 1, 3, 1, {2{64'h7FFF_FFFF_FFFF_FFFF}}, {2{64'h1}}, 1);
  endtask

  task automatic t_ssub();
    do_op("R6", 1, 1, 0, 1, {112'h0, 8'h7F, 8'h80}, {112'h0, 8'hFF, 8'h01}, 1);
    check("R6", result[15:0], 16'h7F80);
    do_op("R6", 1, 1, 1, 1, {8{16'h8000}}, {8{16'h0001}}, 1);
  endtask

  task automatic t_half();
    do_op("R7", 0, 0, 0, 0, {{8{8'hFF}}, {8{8'h01}}}, {{8{8'h01}}, {8{8'h01}}}, 1);
    check("R7", result[127:64], 64'h0);
    check("R7", 128'(sat_flag), 0);
  endtask

  task automatic t_sticky();
    do_op("R8", 0, 0, 0, 1, {16{8'hF0}}, {16{8'h20}}, 1);
    do_op("R8", 0, 0, 0, 1, {16{8'h01}}, {16{8'h01}}, 0);
    check("R8", 128'(sat_flag), 1);
  endtask

  task automatic t_clear();
    @(negedge clk); clr_sat = 1;
    @(negedge clk); clr_sat = 0; exp_sat = 0;
    check("R9", 128'(sat_flag), 0);
    do_op("R9", 0, 0, 0, 1, {16{8'hF0}}, {16{8'h20}}, 1);
    check("R9", 128'(sat_flag), 1);
    do_op("R9", 0, 0, 0, 1, {16{8'h01}}, {16{8'h01}}, 1);
    check("R9", 128'(sat_flag), 0);
  endtask

  task automatic t_hold();
    logic [127:0] keep = result;
    @(negedge clk);
    in_valid = 0; op_sub = 0; is_signed = 0; lane_sel = 0; full_len = 1;
    src_a = {16{8'hFF}}; src_b = {16{8'hFF}};
    @(negedge clk); @(negedge clk);
    check("R10", result, keep);
    check("R10", 128'(sat_flag), 0);
  endtask

  initial begin
    rst = 1; in_valid = 0; op_sub = 0; is_signed = 0; lane_sel = 0;
    full_len = 1; clr_sat = 0; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_lanes();
    t_uadd();
    t_usub();
    t_sadd();
    t_ssub();
    t_half();
    t_sticky();
    t_clear();
    t_hold();
    do_op("R1", 0, 0, 0, 1, {16{8'hFF}}, {16{8'hFF}}, 0);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    t_reset();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule